// File: doc/BRIEF.md
# Partitioned 40-bit General Register File

This block holds a bank of 40-bit data registers for a fixed-point datapath. Every register is made of three fields: a low half (bits 15:0), a high half (bits 31:16) and an extension byte (bits 39:32). Two wider views are also addressable: an upper 24-bit view (bits 39:16) and a lower 32-bit view (bits 31:0). The lower 32-bit view is the operand that normalization and exponent units take.

There is one write port and two read ports. Each port has a register index and a 3-bit view code. A write changes only the bits that its view code names. Two codes do more than a plain field write: a sign-extending load into the high half that also clears the low half, and a sign-extending load into the upper 24-bit view. Reads are combinational. A read returns the selected view right-aligned on a 40-bit bus, with zeros above the view width. Forwarding a result that is written in the same cycle is the job of the surrounding pipeline.

All ports are plain control and data pins with no handshake. A write is taken on every clock edge at which `wr_en` is high, and the block never applies back-pressure.

Top module: `gpr40_regfile`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` = 0) clears every register to zero. This holds when registers have been written before the reset.
- R2: View code 0 (full) reads all 40 bits, and a write with it stores `wr_data[39:0]`.
- R3: View code 1 (high load) writes `wr_data[15:0]` into bits 31:16, copies `wr_data[15]` into all of bits 39:32 and clears bits 15:0. A read with code 1 returns bits 31:16.
- R4: View code 5 (upper 24) writes `wr_data[15:0]` sign-extended to 24 bits into bits 39:16 and leaves bits 15:0 unchanged. A read with code 5 returns bits 39:16.
- R5: View code 6 (lower 32) writes `wr_data[31:0]` into bits 31:0 and leaves bits 39:32 unchanged. A read with code 6 returns bits 31:0.
- R6: View code 2 (high) reads or writes bits 31:16 alone, using `wr_data[15:0]`. All other bits are unchanged.
- R7: View code 3 (low) reads or writes bits 15:0 alone, using `wr_data[15:0]`. All other bits are unchanged.
- R8: View code 4 (extension) reads or writes bits 39:32 alone, using `wr_data[7:0]`. All other bits are unchanged.
- R9: A read in any view narrower than 40 bits places the view at bit 0 and drives zeros above it.
- R10: A read in the same cycle as a write to the same register returns the value from before the write. The new value is visible from the next cycle.
- R11: View code 7 is reserved. A write with it changes no register, and a read with it returns zero.
- R12: The two read ports are independent. Each returns its own index and view in the same cycle, and both agree when they are given the same index and view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Index of the register to write |
| wr_mode | input | 3 | View code for the write |
| wr_data | input | 40 | Write data; the view code selects which bits are used |
| rd0_idx | input | 3 | Index for read port 0 |
| rd0_mode | input | 3 | View code for read port 0 |
| rd0_data | output | 40 | Read port 0 data, right-aligned and zero-filled |
| rd1_idx | input | 3 | Index for read port 1 |
| rd1_mode | input | 3 | View code for read port 1 |
| rd1_data | output | 40 | Read port 1 data, right-aligned and zero-filled |

## Verification
The bench writes each field view over registers preloaded with all ones or with mixed patterns. A merge that overwrote its neighbours would show up as wrong bits in the fields next to the one written. Both sign-extending loads are driven with negative and positive values. This catches a load that zero-extends, a high load that keeps the old low half, and an upper-24 load that clears it. Reads on the same cycle as a write to the same index expose a design that passes new data through the read path. Reserved-code writes and reads expose a decoder that falls through to one of the real views. A reset issued after many writes exposes a register that is not cleared.

// File: rtl/gpr40_pkg.sv
package gpr40_pkg;
  localparam int LO_W   = 16;
  localparam int HI_W   = 16;
  localparam int EXT_W  = 8;
  localparam int WORD_W = LO_W + HI_W + EXT_W;
  localparam int U24_W  = HI_W + EXT_W;
  localparam int L32_W  = LO_W + HI_W;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    VIEW_FULL    = 3'd0,
    VIEW_HI_LOAD = 3'd1,
    VIEW_HI      = 3'd2,
    VIEW_LO      = 3'd3,
    VIEW_EXT     = 3'd4,
    VIEW_UPPER24 = 3'd5,
    VIEW_LOWER32 = 3'd6,
    VIEW_NONE    = 3'd7
  } view_e;

  typedef struct packed {
    logic [EXT_W-1:0] ext;
    logic [HI_W-1:0]  hi;
    logic [LO_W-1:0]  lo;
  } word_t;
endpackage

// File: rtl/gpr40_write_merge.sv
module gpr40_write_merge
  import gpr40_pkg::*;
(
  input  word_t             old_word,
  input  view_e             mode,
  input  logic [WORD_W-1:0] din,
  output word_t             new_word
);
  logic             hi_sign;
  logic [HI_W-1:0]  din_hi16;

  assign din_hi16 = din[HI_W-1:0];
  assign hi_sign  = din[HI_W-1];

  always_comb begin
    new_word = old_word;
    case (mode)
      VIEW_FULL: new_word = word_t'(din);
      VIEW_HI_LOAD: begin
        new_word.hi  = din_hi16;
        new_word.ext = {EXT_W{hi_sign}};
        new_word.lo  = '0;
      end
      VIEW_HI:  new_word.hi  = din_hi16;
      VIEW_LO:  new_word.lo  = din[LO_W-1:0];
      VIEW_EXT: new_word.ext = din[EXT_W-1:0];
      VIEW_UPPER24: begin
        new_word.hi  = din_hi16;
        new_word.ext = {EXT_W{hi_sign}};
      end
      VIEW_LOWER32: begin
        new_word.hi = din[L32_W-1:LO_W];
        new_word.lo = din[LO_W-1:0];
      end
      default: new_word = old_word;
    endcase
  end
endmodule

// File: rtl/gpr40_read_view.sv
module gpr40_read_view
  import gpr40_pkg::*;
(
  input  word_t             word,
  input  view_e             mode,
  output logic [WORD_W-1:0] dout
);
  always_comb begin
    dout = '0;
    case (mode)
      VIEW_FULL:               dout = word;
      VIEW_HI_LOAD, VIEW_HI:   dout[HI_W-1:0]  = word.hi;
      VIEW_LO:                 dout[LO_W-1:0]  = word.lo;
      VIEW_EXT:                dout[EXT_W-1:0] = word.ext;
      VIEW_UPPER24:            dout[U24_W-1:0] = {word.ext, word.hi};
      VIEW_LOWER32:            dout[L32_W-1:0] = {word.hi, word.lo};
      default:                 dout = '0;
    endcase
  end
endmodule

// File: rtl/gpr40_bank.sv
module gpr40_bank
  import gpr40_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  word_t                     wr_word,
  output word_t [NUM_REGS-1:0]      regs_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wr_word;
      end
    end
  end
endmodule

// File: rtl/gpr40_regfile.sv
module gpr40_regfile
  import gpr40_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NUM_RD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [MODE_W-1:0]  wr_mode,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd0_idx,
  input  logic [MODE_W-1:0]  rd0_mode,
  output logic [WORD_W-1:0]  rd0_data,
  input  logic [IDX_W-1:0]   rd1_idx,
  input  logic [MODE_W-1:0]  rd1_mode,
  output logic [WORD_W-1:0]  rd1_data
);
  word_t [NUM_REGS-1:0] regs_q;
  word_t                old_word;
  word_t                new_word;

  function automatic word_t pick(input word_t [NUM_REGS-1:0] r, input logic [IDX_W-1:0] i);
    word_t w;
    w = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (i == IDX_W'(k)) w = r[k];
    end
    return w;
  endfunction

  assign old_word = pick(regs_q, wr_idx);

  gpr40_write_merge u_merge (
    .old_word (old_word),
    .mode     (view_e'(wr_mode)),
    .din      (wr_data),
    .new_word (new_word)
  );

  gpr40_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word (new_word),
    .regs_q  (regs_q)
  );

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][MODE_W-1:0] rd_mode;
  logic [NUM_RD-1:0][WORD_W-1:0] rd_data;

  assign rd_idx  = {rd1_idx, rd0_idx};
  assign rd_mode = {rd1_mode, rd0_mode};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr40_read_view u_view (
      .word (pick(regs_q, rd_idx[p])),
      .mode (view_e'(rd_mode[p])),
      .dout (rd_data[p])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];
endmodule

// File: rtl/gpr40_regfile_checker.sv
module gpr40_regfile_checker
  import gpr40_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [MODE_W-1:0]  wr_mode,
  input logic [WORD_W-1:0]  wr_data,
  input logic [IDX_W-1:0]   rd0_idx,
  input logic [MODE_W-1:0]  rd0_mode,
  input logic [WORD_W-1:0]  rd0_data,
  input logic [IDX_W-1:0]   rd1_idx,
  input logic [MODE_W-1:0]  rd1_mode,
  input logic [WORD_W-1:0]  rd1_data
);
  logic same_full0;
  assign same_full0 = (rd0_mode == MODE_W'(VIEW_FULL));

  // R3: high load shape seen on a following full read of the same register
  a_r3_hi_load_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_W'(VIEW_HI_LOAD)) |=>
    (!(rd0_idx == $past(wr_idx) && same_full0) ||
     rd0_data == {{EXT_W{$past(wr_data[HI_W-1])}}, $past(wr_data[HI_W-1:0]), {LO_W{1'b0}}}));

  // R7: low write keeps bits above the low half
  a_r7_lo_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_W'(VIEW_LO) && rd0_idx == wr_idx && same_full0) |=>
    (!(rd0_idx == $past(wr_idx) && same_full0) ||
     rd0_data == {$past(rd0_data[WORD_W-1:LO_W]), $past(wr_data[LO_W-1:0])}));

  // R8: extension write keeps bits 31:0
  a_r8_ext_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_W'(VIEW_EXT) && rd0_idx == wr_idx && same_full0) |=>
    (!(rd0_idx == $past(wr_idx) && same_full0) ||
     rd0_data == {$past(wr_data[EXT_W-1:0]), $past(rd0_data[L32_W-1:0])}));

  // R9: narrow 16-bit views are zero above bit 15
  a_r9_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_mode == MODE_W'(VIEW_LO) || rd1_mode == MODE_W'(VIEW_HI) ||
     rd1_mode == MODE_W'(VIEW_HI_LOAD)) |-> (rd1_data[WORD_W-1:LO_W] == '0));

  // R10: without a write, a held full read stays stable
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && same_full0) |=>
    (!(rd0_idx == $past(rd0_idx) && same_full0) || $stable(rd0_data)));

  // R11: reserved write changes nothing, reserved read is zero
  a_r11_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_W'(VIEW_NONE) && rd0_idx == wr_idx && same_full0) |=>
    (!(rd0_idx == $past(rd0_idx) && same_full0) || $stable(rd0_data)));

  a_r11_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_mode == MODE_W'(VIEW_NONE)) |-> (rd0_data == '0));

  // R12: both ports agree on the same index and view
  a_r12_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == rd1_idx && rd0_mode == rd1_mode) |-> (rd0_data == rd1_data));
endmodule

bind gpr40_regfile gpr40_regfile_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode),
  .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_mode(rd0_mode), .rd0_data(rd0_data),
  .rd1_idx(rd1_idx), .rd1_mode(rd1_mode), .rd1_data(rd1_data)
);

// File: tb/gpr40_regfile_bench.sv
module gpr40_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [2:0]  wr_mode = '0;
  logic [39:0] wr_data = '0;
  logic [2:0]  rd0_idx = '0, rd1_idx = '0;
  logic [2:0]  rd0_mode = '0, rd1_mode = '0;
  logic [39:0] rd0_data, rd1_data;

  gpr40_regfile u_gpr40_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode),
    .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_mode(rd0_mode), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_mode(rd1_mode), .rd1_data(rd1_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    int          port;
    logic [39:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [39:0] model [8];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [39:0] exp_read(logic [39:0] w, int m);
    case (m)
      0:       return w;
      1, 2:    return {24'h0, w[31:16]};
      3:       return {24'h0, w[15:0]};
      4:       return {32'h0, w[39:32]};
      5:       return {16'h0, w[39:16]};
      6:       return {8'h0, w[31:0]};
      default: return 40'h0;
    endcase
  endfunction

  function automatic logic [39:0] exp_write(logic [39:0] w, int m, logic [39:0] d);
    logic [7:0] sx;
    sx = d[15] ? 8'hFF : 8'h00;
    case (m)
      0:       return d;
      1:       return {sx, d[15:0], 16'h0};
      2:       return {w[39:32], d[15:0], w[15:0]};
      3:       return {w[39:16], d[15:0]};
      4:       return {d[7:0], w[31:0]};
      5:       return {sx, d[15:0], w[15:0]};
      6:       return {w[39:32], d[31:0]};
      default: return w;
    endcase
  endfunction

  task automatic step(bit we, int wi, int wm, logic [39:0] wd,
                      int i0, int m0, int i1, int m1, string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = we; wr_idx = 3'(wi); wr_mode = 3'(wm); wr_data = wd;
    rd0_idx = 3'(i0); rd0_mode = 3'(m0); rd1_idx = 3'(i1); rd1_mode = 3'(m1);
    it.cyc = cyc; it.tag = tag;
    it.port = 0; it.exp = exp_read(model[i0], m0); sb_q.push_back(it);
    it.port = 1; it.exp = exp_read(model[i1], m1); sb_q.push_back(it);
    if (we) model[wi] = exp_write(model[wi], wm, wd);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    wr_en = 0;
    rst_n = 0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // monitor: pops expected items for the current cycle and compares
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      item_t it;
      logic [39:0] act;
      it = sb_q.pop_front();
      act = (it.port == 0) ? rd0_data : rd1_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s port%0d cycle %0d: actual %h expected %h",
                 it.tag, it.port, it.cyc, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state of all registers
    for (int k = 0; k < 8; k += 2) step(0, 0, 0, 0, k, 0, k + 1, 0, "R1");

    // R2: full write and read; R5 lower-32 read
    step(1, 1, 0, 40'hA5_1234_5678, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, 1, 6, "R2");

    // R10: same-cycle read sees old value, next cycle sees new
    step(1, 2, 0, 40'h12_3456_789A, 2, 0, 2, 3, "R10");
    step(0, 0, 0, 0, 2, 0, 2, 4, "R10");

    // R3: high load, negative and positive, over all-ones
    step(1, 3, 0, 40'hFF_FFFF_FFFF, 3, 0, 3, 0, "R3");
    step(1, 3, 1, 40'h00_0000_8001, 3, 0, 3, 1, "R3");
    step(0, 0, 0, 0, 3, 0, 3, 1, "R3");
    step(1, 3, 0, 40'hFF_FFFF_FFFF, 3, 0, 3, 0, "R3");
    step(1, 3, 1, 40'hAB_CDEF_7FFE, 3, 0, 3, 0, "R3");
    step(0, 0, 0, 0, 3, 0, 3, 4, "R3");

    // R4: upper-24 sign-extending load keeps low half
    step(1, 4, 0, 40'h00_0000_BEEF, 4, 0, 4, 0, "R4");
    step(1, 4, 5, 40'h00_0000_9000, 4, 0, 4, 5, "R4");
    step(1, 4, 5, 40'hFF_FFFF_1234, 4, 0, 4, 5, "R4");
    step(0, 0, 0, 0, 4, 0, 4, 5, "R4");

    // R5: lower-32 write keeps extension
    step(1, 5, 0, 40'h7E_0000_0000, 5, 0, 5, 0, "R5");
    step(1, 5, 6, 40'hFF_CAFE_F00D, 5, 0, 5, 6, "R5");
    step(0, 0, 0, 0, 5, 0, 5, 6, "R5");

    // R6, R7, R8: single-field writes
    step(1, 6, 0, 40'h11_2222_3333, 6, 0, 6, 0, "R6");
    step(1, 6, 2, 40'hFF_FFFF_ABCD, 6, 0, 6, 2, "R6");
    step(1, 6, 3, 40'hFF_FFFF_5E5E, 6, 0, 6, 2, "R7");
    step(1, 6, 4, 40'hFF_FFFF_FF5A, 6, 0, 6, 3, "R7");
    step(0, 0, 0, 0, 6, 0, 6, 4, "R8");

    // R9: each narrow view read on a register with all bits set
    step(1, 7, 0, 40'hFF_FFFF_FFFF, 7, 0, 7, 0, "R9");
    step(0, 0, 0, 0, 7, 1, 7, 2, "R9");
    step(0, 0, 0, 0, 7, 3, 7, 4, "R9");
    step(0, 0, 0, 0, 7, 5, 7, 6, "R9");

    // R11: reserved write ignored, reserved read zero
    step(1, 6, 7, 40'h00_0000_0000, 6, 0, 6, 7, "R11");
    step(1, 7, 7, 40'h00_0000_0000, 6, 0, 7, 7, "R11");
    step(0, 0, 0, 0, 6, 0, 7, 0, "R11");

    // R12: independent ports, mixed indices and views
    step(0, 0, 0, 0, 1, 4, 5, 5, "R12");
    step(0, 0, 0, 0, 3, 6, 3, 6, "R12");

    // R2: pattern sweep over every register
    for (int k = 0; k < 8; k++)
      step(1, k, 0, {8'(k * 17 + 3), 16'(k * 4099 + 1), 16'(~(k * 257))},
           (k + 7) % 8, 0, k, 0, "R2");
    for (int k = 0; k < 8; k += 2) step(0, 0, 0, 0, k, 0, k + 1, 0, "R2");

    // R1: reset after writes clears everything
    do_reset();
    for (int k = 0; k < 8; k += 2) step(0, 0, 0, 0, k, 0, k + 1, 0, "R1");

    @(posedge clk); #1 wr_en = 0;
    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule